// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block steps a 12-bit successive approximation conversion one bit per conversion clock. It owns the trial register whose bits drive an external feedback DAC. Once per rising edge it reads a one-bit comparator verdict. When a conversion has finished, the same register holds the parallel result. The comparator, DAC, sample-and-hold and any input multiplexer sit outside the block.

The trial level of a bit is 0 and the resting level is 1. A kept bit therefore reads 0, and an idle or reset register reads all ones. Two start styles are supported. In level mode, the start input is active low and is sampled on a rising edge. The sequence then waits until the input is released. In edge mode, a high start input while the block is idle launches a conversion, and bit testing begins on the very next edge. A busy flag covers the whole conversion. Each decision also leaves the block on a serial line, MSB first. The serial line only changes on rising edges, so a receiver can capture it on falling edges.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block idle: busy is 0, all twelve result bits are 1 and the serial output is 1. This holds even in the middle of a conversion.
- R2: In level mode (pos_mode = 0), start_in low at a rising edge while idle raises busy on that edge. start_in high while idle starts nothing.
- R3: After a level-mode request, as long as start_in stays low, busy stays 1 and the result register keeps its previous value.
- R4: On the first rising edge at which the request is no longer active, the register loads 0x7FF: bit 11 (MSB) at 0 and bits 10..0 at 1.
- R5: On each of the next twelve edges, the bit under test becomes 0 if cmp_in is 1 and 1 if cmp_in is 0. On the same edge the next lower bit is cleared to 0. Bits below that one stay at 1.
- R6: Decisions run from bit 11 down to bit 0, one per edge, twelve in all. With the comparator reporting input >= complement of the code, the final result is the bitwise complement of the input level.
- R7: busy stays 1 through the LSB decision and falls on the following edge. That edge comes 14 edges after the request edge and 13 edges after the first trial edge.
- R8: On each decision edge, ser_out takes the value of the bit just decided (MSB first). It does not change on any other edge.
- R9: In edge mode (pos_mode = 1), start_in high at a rising edge while idle raises busy. The first trial edge follows on the next edge whatever start_in does. start_in low while idle starts nothing.
- R10: start_in has no effect while a conversion is running. The decisions, the result and the finishing edge are those of an undisturbed conversion.
- R11: After busy falls, the result register holds its value until the first trial edge of the next conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_in | input | 1 | Conversion request; active low in level mode, active high in edge mode |
| pos_mode | input | 1 | 0 selects level-mode start, 1 selects edge-mode start |
| cmp_in | input | 1 | Comparator verdict: 1 keeps the bit under test at 0 |
| dac_code | output | 12 | Trial register to the DAC; parallel result once busy falls |
| busy | output | 1 | High from request recognition until the edge after the LSB decision |
| ser_out | output | 1 | Most recent decided bit, MSB first |

## Verification
The assertions assume the comparator input settles before each rising edge. They also assume pos_mode is changed only while the block is idle and that reset is held from time zero. The bench drives every input on falling edges and computes cmp_in combinationally from dac_code against a held input level. pos_mode is set only between conversions. The start line is toggled at random during conversions to show that it is ignored. In edge mode, the start line is brought low before the finishing edge, so a new conversion begins only when the bench asks for one.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_TEST   = 2'd2,
    ST_FINISH = 2'd3
  } sar_state_t;

  // level a bit under test settles to, given the comparator verdict
  function automatic logic decided_level(input logic keep_cleared);
    return keep_cleared ? 1'b0 : 1'b1;
  endfunction

  // level a bit takes when it becomes the bit under test
  localparam logic TRIAL_LEVEL = 1'b0;
  localparam logic REST_LEVEL  = 1'b1;

endpackage

// File: rtl/sar_start_qual.sv
module sar_start_qual (
  input  logic start_in,
  input  logic pos_mode,
  input  logic busy,
  output logic req_active
);

  // level mode: low request; edge mode: high request gated by idle status,
  // which releases itself as soon as busy rises
  always_comb begin
    if (pos_mode) req_active = start_in & ~busy;
    else          req_active = ~start_in;
  end

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_ctrl_pkg::*;
#(
  parameter int W = 12,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_active,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy,
  output logic             req_seen,
  output logic             test_begin,
  output logic             bit_decide,
  output logic             last_decide,
  output logic             conv_done
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  sar_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_idx <= TOP_IDX;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_active) state_q <= ST_ARMED;
        end
        ST_ARMED: begin
          if (!req_active) begin
            state_q <= ST_TEST;
            bit_idx <= TOP_IDX;
          end
        end
        ST_TEST: begin
          if (bit_idx == '0) state_q <= ST_FINISH;
          else               bit_idx <= bit_idx - 1'b1;
        end
        ST_FINISH: begin
          state_q <= ST_IDLE;
          bit_idx <= TOP_IDX;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign req_seen    = (state_q == ST_IDLE) && req_active;
  assign test_begin  = (state_q == ST_ARMED) && !req_active;
  assign bit_decide  = (state_q == ST_TEST);
  assign last_decide = (state_q == ST_TEST) && (bit_idx == '0);
  assign conv_done   = (state_q == ST_FINISH);

endmodule

// File: rtl/sar_result_reg.sv
module sar_result_reg
  import sar_ctrl_pkg::*;
#(
  parameter int W = 12,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_begin,
  input  logic             bit_decide,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_in,
  output logic [W-1:0]     code,
  output logic             ser_out
);

  logic verdict;
  assign verdict = decided_level(cmp_in);

  // one flop per result bit, each decoding its own role from the index
  for (genvar g = 0; g < W; g++) begin : g_bit
    localparam logic SEED = (g == W - 1) ? TRIAL_LEVEL : REST_LEVEL;
    logic is_tested;
    logic is_next;
    assign is_tested = (int'(bit_idx) == g);
    assign is_next   = (int'(bit_idx) == g + 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        code[g] <= REST_LEVEL;
      end else if (test_begin) begin
        code[g] <= SEED;
      end else if (bit_decide) begin
        if (is_tested)    code[g] <= verdict;
        else if (is_next) code[g] <= TRIAL_LEVEL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             ser_out <= REST_LEVEL;
    else if (bit_decide) ser_out <= verdict;
  end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_in,
  input  logic         pos_mode,
  input  logic         cmp_in,
  output logic [W-1:0] dac_code,
  output logic         busy,
  output logic         ser_out
);

  localparam int IDX_W = (W > 1) ? $clog2(W) : 1;

  logic             req_active;
  logic [IDX_W-1:0] bit_idx;
  logic             req_seen;
  logic             test_begin;
  logic             bit_decide;
  logic             last_decide;
  logic             conv_done;

  sar_start_qual u_start_qual (
    .start_in   (start_in),
    .pos_mode   (pos_mode),
    .busy       (busy),
    .req_active (req_active)
  );

  sar_sequencer #(.W(W)) u_sequencer (
    .clk         (clk),
    .rst         (rst),
    .req_active  (req_active),
    .bit_idx     (bit_idx),
    .busy        (busy),
    .req_seen    (req_seen),
    .test_begin  (test_begin),
    .bit_decide  (bit_decide),
    .last_decide (last_decide),
    .conv_done   (conv_done)
  );

  sar_result_reg #(.W(W)) u_result_reg (
    .clk        (clk),
    .rst        (rst),
    .test_begin (test_begin),
    .bit_decide (bit_decide),
    .bit_idx    (bit_idx),
    .cmp_in     (cmp_in),
    .code       (dac_code),
    .ser_out    (ser_out)
  );

endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         cmp_in,
  input logic         busy,
  input logic         ser_out,
  input logic [W-1:0] dac_code,
  input logic         req_seen,
  input logic         test_begin,
  input logic         bit_decide,
  input logic         last_decide,
  input logic         conv_done
);

  localparam logic [W-1:0] FIRST_TRIAL = W'((1 << (W - 1)) - 1);

  assert_request_busy_R2: assert property (@(posedge clk) disable iff (rst)
    req_seen |=> busy);

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
    test_begin |=> (dac_code == FIRST_TRIAL) && busy);

  assert_serial_value_R8: assert property (@(posedge clk) disable iff (rst)
    bit_decide |=> (ser_out == !$past(cmp_in)));

  assert_serial_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !bit_decide |=> $stable(ser_out));

  assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> !busy);

  assert_busy_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !conv_done) |=> busy);

  assert_decisions_run_R10: assert property (@(posedge clk) disable iff (rst)
    (bit_decide && !last_decide) |=> bit_decide);

  assert_last_then_done_R6: assert property (@(posedge clk) disable iff (rst)
    last_decide |=> conv_done);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(dac_code));

endmodule

bind sar_conv_ctrl sar_conv_chk #(.W(W)) u_sar_conv_chk (
  .clk         (clk),
  .rst         (rst),
  .cmp_in      (cmp_in),
  .busy        (busy),
  .ser_out     (ser_out),
  .dac_code    (dac_code),
  .req_seen    (req_seen),
  .test_begin  (test_begin),
  .bit_decide  (bit_decide),
  .last_decide (last_decide),
  .conv_done   (conv_done)
);

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int WATCHDOG_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_in = 1'b1;
  logic         pos_mode = 1'b0;
  logic         cmp_in;
  logic [W-1:0] dac_code;
  logic         busy;
  logic         ser_out;
  logic [W-1:0] vin = '0;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural comparator: input level against the analog weight of the code
  assign cmp_in = (vin >= ~dac_code);

  sar_conv_ctrl #(.W(W)) i_sar_conv_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_in (start_in),
    .pos_mode (pos_mode),
    .cmp_in   (cmp_in),
    .dac_code (dac_code),
    .busy     (busy),
    .ser_out  (ser_out)
  );

  // binary search in true-binary terms, result stored complemented
  function automatic logic [W-1:0] ref_result(input logic [W-1:0] v);
    logic [W-1:0] t = '0;
    for (int b = W - 1; b >= 0; b--) begin
      logic [W-1:0] cand = t | (W'(1) << b);
      if (cand <= v) t = cand;
    end
    return ~t;
  endfunction

  // register content after decision number k (0 = MSB decision)
  function automatic logic [W-1:0] ref_partial(input logic [W-1:0] v, input int k);
    logic [W-1:0] r = ref_result(v);
    logic [W-1:0] p = '1;
    for (int b = 0; b < W; b++) begin
      if (b >= W - 1 - k)      p[b] = r[b];
      else if (b == W - 2 - k) p[b] = 1'b0;
    end
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  // one conversion; hold_cycles extra low cycles in level mode, noise toggles start
  task automatic run_conv(input bit mode, input logic [W-1:0] v,
                          input int hold_cycles, input bit noise);
    logic [W-1:0] prev;
    logic [W-1:0] r;
    r = ref_result(v);
    @(negedge clk);
    prev = dac_code;
    pos_mode = mode;
    vin = v;
    start_in = mode ? 1'b1 : 1'b0;
    @(negedge clk);
    check(mode ? "R9 busy on high start" : "R2 busy on low start", 32'(busy), 32'd1);
    check("R3 result untouched at request", 32'(dac_code), 32'(prev));
    if (!mode) begin
      for (int i = 0; i < hold_cycles; i++) begin
        @(negedge clk);
        check("R3 busy while held", 32'(busy), 32'd1);
        check("R3 no testing while held", 32'(dac_code), 32'(prev));
      end
      start_in = 1'b1;
    end else if (noise) begin
      start_in = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    check(mode ? "R9 first trial next edge" : "R4 first trial word", 32'(dac_code), 32'h7FF);
    for (int k = 0; k < W; k++) begin
      if (noise) start_in = 1'($urandom_range(0, 1));
      @(negedge clk);
      check("R5 partial register", 32'(dac_code), 32'(ref_partial(v, k)));
      check("R8 serial bit", 32'(ser_out), 32'(r[W-1-k]));
      check(noise ? "R10 busy despite start" : "R7 busy during decisions", 32'(busy), 32'd1);
    end
    start_in = mode ? 1'b0 : 1'b1;
    @(negedge clk);
    check("R7 busy clears after LSB", 32'(busy), 32'd0);
    check(noise ? "R10 result with noisy start" : "R6 final result", 32'(dac_code), 32'(r));
    check("R8 serial holds at finish", 32'(ser_out), 32'(r[0]));
    @(negedge clk);
    @(negedge clk);
    check("R11 result held idle", 32'(dac_code), 32'(r));
    check("R11 still idle", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A12));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset busy", 32'(busy), 32'd0);
    check("R1 reset code", 32'(dac_code), 32'hFFF);
    check("R1 reset serial", 32'(ser_out), 32'd1);

    // idle with inactive start levels: nothing happens
    start_in = 1'b1;
    pos_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 high start idle", 32'(busy), 32'd0);
    pos_mode = 1'b1;
    start_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 low start idle", 32'(busy), 32'd0);
    start_in = 1'b1;
    pos_mode = 1'b0;

    // directed corners
    run_conv(1'b0, 12'h000, 0, 1'b0);
    run_conv(1'b0, 12'hFFF, 3, 1'b0);
    run_conv(1'b1, 12'h800, 0, 1'b0);
    run_conv(1'b1, 12'h7FF, 0, 1'b1);
    run_conv(1'b0, 12'hA5A, 1, 1'b1);

    // reset in the middle of a conversion
    @(negedge clk);
    pos_mode = 1'b0;
    vin = 12'h123;
    start_in = 1'b0;
    @(negedge clk);
    start_in = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid reset busy", 32'(busy), 32'd0);
    check("R1 mid reset code", 32'(dac_code), 32'hFFF);
    check("R1 mid reset serial", 32'(ser_out), 32'd1);

    // random mix
    for (int n = 0; n < 30; n++) begin
      run_conv(1'($urandom_range(0, 1)), W'($urandom), $urandom_range(0, 3),
               1'($urandom_range(0, 1)));
    end

    finish_run();
  end

endmodule